// File: doc/BRIEF.md
# Dual Stacks with Register-Cached Tops

This block keeps the two stacks of a small stack-machine core: a data stack and a return stack. The two newest data entries are kept in registers, named T (top) and S (second). The newest return entry is kept in register R. Older entries of each stack go into a circular buffer of their own. All three cached registers drive the datapath directly, so the ALU and the branch logic see them with no memory read in the way.

Each stack takes its own push and pop strobes. A push moves values down through the cached registers and into the buffer. A pop moves values up out of the buffer. The value a pop removes is driven in the same cycle as the pop strobe. The register updates take effect at the next rising clock edge.

Neither buffer detects overflow or underflow. A buffer that overflows wraps and overwrites its oldest entry. Popping an empty buffer yields whatever entry the circular pointer reaches. The core's control logic must track stack depth if it needs to.

Top module: `dual_stack_cache`

## Requirements
- R1: While `rst` is high at a rising edge, T, S and R become zero on that edge and both buffer pointers return to their start position.
- R2: A data push alone (`dpush`=1, `dpop`=0) with value w sets T to w and S to the old T, and stores the old S in the data buffer.
- R3: A data pop alone (`dpop`=1, `dpush`=0) sets T to the old S and loads S from the newest entry of the data buffer.
- R4: A return push alone with value w sets R to w and stores the old R in the return buffer.
- R5: A return pop alone loads R from the newest entry of the return buffer.
- R6: Each buffer holds DEPTH entries, 8 by default. With more pushes than that, the buffer wraps silently, so a stack always returns its newest DEPTH plus cached entries in last-in, first-out order.
- R7: Pops past the last stored entry raise no flag. They return the entries the wrapped pointer reaches, which are the values from earlier laps.
- R8: The data stack and the return stack work independently. Commands to both stacks in the same cycle have the same effect as if each were issued alone.
- R9: A push and a pop to the same stack in one cycle replace its top register with the new value. The pop output still gives the old top, and the buffer and S do not change.
- R10: `dpop_val` equals T and `rpop_val` equals R in the cycle of the pop command. The cached registers change only at the following rising edge.
- R11: With no command to a stack, its cached registers and its buffer keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dpush | input | 1 | Push `dwdata` onto the data stack |
| dpop | input | 1 | Pop the data stack |
| dwdata | input | WORD_W | Value pushed onto the data stack |
| rpush | input | 1 | Push `rwdata` onto the return stack |
| rpop | input | 1 | Pop the return stack |
| rwdata | input | WORD_W | Value pushed onto the return stack |
| top_t | output | WORD_W | Data-stack top register T |
| top_s | output | WORD_W | Data-stack second register S |
| top_r | output | WORD_W | Return-stack top register R |
| dpop_val | output | WORD_W | Value removed by a data pop in this cycle |
| rpop_val | output | WORD_W | Value removed by a return pop in this cycle |

## Verification
The embedded properties check every single-cycle transfer on every clock:
- values moving between T, S and R on push, pop, combined and idle cycles;
- the reset values;
- that a value written to a buffer is the next one it presents.

Other behaviour involves many cycles and the buffer contents, so only the bench's scenarios can show it:
- last-in, first-out order over long sequences;
- overwriting on wrap-around, and the stale values read when popping past empty;
- independence of the two stacks under mixed random traffic, checked against a reference model of both stacks.

// File: rtl/dstk_pkg.sv
package dstk_pkg;
  localparam int unsigned WORD_W_DEF = 18;
  localparam int unsigned DEPTH_DEF  = 8;

  // Per-stack command, {pop, push}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    return stk_op_e'({pop, push});
  endfunction
endpackage

// File: rtl/dstk_ring.sv
module dstk_ring #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top_rd
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] rd_addr;

  // ptr names the next free slot; it wraps silently on a power-of-two depth
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (push) ptr <= ptr + PW'(1);
    else if (pop)  ptr <= ptr - PW'(1);
  end

  // Storage without reset, single write port
  always_ff @(posedge clk) begin
    if (push) mem[ptr] <= wdata;
  end

  assign rd_addr = ptr - PW'(1);
  assign top_rd  = mem[rd_addr];

  // R6
  ring_excl_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));

  // R2
  ring_write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> (top_rd == $past(wdata)));

  // R11
  ring_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(top_rd));
endmodule

// File: rtl/dstk_data.sv
module dstk_data
  import dstk_pkg::*;
#(
  parameter int unsigned W     = WORD_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] t_q,
  output logic [W-1:0] s_q,
  output logic [W-1:0] pop_val
);
  stk_op_e      op;
  logic         ring_push;
  logic         ring_pop;
  logic [W-1:0] ring_top;

  assign op        = decode_op(push, pop);
  assign ring_push = (op == OP_PUSH);
  assign ring_pop  = (op == OP_POP);

  dstk_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .push  (ring_push),
    .pop   (ring_pop),
    .wdata (s_q),
    .top_rd(ring_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q <= '0;
      s_q <= '0;
    end else begin
      unique case (op)
        OP_PUSH: begin
          t_q <= wdata;
          s_q <= t_q;
        end
        OP_POP: begin
          t_q <= s_q;
          s_q <= ring_top;
        end
        OP_SWAP: t_q <= wdata;
        default: ;
      endcase
    end
  end

  assign pop_val = t_q;

  // R1
  data_reset_chk: assert property (@(posedge clk)
    rst |=> (t_q == '0 && s_q == '0));

  // R2
  data_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (t_q == $past(wdata) && s_q == $past(t_q)));

  // R3
  data_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (t_q == $past(s_q) && s_q == $past(ring_top)));

  // R9
  data_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && push) |=> (t_q == $past(wdata) && $stable(s_q)));

  // R11
  data_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!pop && !push) |=> ($stable(t_q) && $stable(s_q)));
endmodule

// File: rtl/dstk_ret.sv
module dstk_ret
  import dstk_pkg::*;
#(
  parameter int unsigned W     = WORD_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] r_q,
  output logic [W-1:0] pop_val
);
  stk_op_e      op;
  logic         ring_push;
  logic         ring_pop;
  logic [W-1:0] ring_top;

  assign op        = decode_op(push, pop);
  assign ring_push = (op == OP_PUSH);
  assign ring_pop  = (op == OP_POP);

  dstk_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .push  (ring_push),
    .pop   (ring_pop),
    .wdata (r_q),
    .top_rd(ring_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q <= '0;
    end else begin
      unique case (op)
        OP_PUSH: r_q <= wdata;
        OP_POP:  r_q <= ring_top;
        OP_SWAP: r_q <= wdata;
        default: ;
      endcase
    end
  end

  assign pop_val = r_q;

  // R1
  ret_reset_chk: assert property (@(posedge clk)
    rst |=> (r_q == '0));

  // R4
  ret_push_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> (r_q == $past(wdata)));

  // R5
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (r_q == $past(ring_top)));

  // R11
  ret_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!pop && !push) |=> $stable(r_q));
endmodule

// File: rtl/dual_stack_cache.sv
module dual_stack_cache
  import dstk_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dpush,
  input  logic              dpop,
  input  logic [WORD_W-1:0] dwdata,
  input  logic              rpush,
  input  logic              rpop,
  input  logic [WORD_W-1:0] rwdata,
  output logic [WORD_W-1:0] top_t,
  output logic [WORD_W-1:0] top_s,
  output logic [WORD_W-1:0] top_r,
  output logic [WORD_W-1:0] dpop_val,
  output logic [WORD_W-1:0] rpop_val
);
  dstk_data #(.W(WORD_W), .DEPTH(DEPTH)) u_data (
    .clk    (clk),
    .rst    (rst),
    .push   (dpush),
    .pop    (dpop),
    .wdata  (dwdata),
    .t_q    (top_t),
    .s_q    (top_s),
    .pop_val(dpop_val)
  );

  dstk_ret #(.W(WORD_W), .DEPTH(DEPTH)) u_ret (
    .clk    (clk),
    .rst    (rst),
    .push   (rpush),
    .pop    (rpop),
    .wdata  (rwdata),
    .r_q    (top_r),
    .pop_val(rpop_val)
  );

  // R10
  always_comb begin
    if (!rst) begin
      pop_visible_chk: assert (dpop_val == top_t && rpop_val == top_r);
    end
  end

  // R8
  stacks_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (!dpush && !dpop && (rpush || rpop)) |=> ($stable(top_t) && $stable(top_s)));
endmodule

// File: tb/dual_stack_cache_tb.sv
module dual_stack_cache_tb;
  localparam int W        = 18;
  localparam int D        = 8;
  localparam time CLK_PER = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic         dpush, dpop, rpush, rpop;
  logic [W-1:0] dwdata, rwdata;
  logic [W-1:0] top_t, top_s, top_r, dpop_val, rpop_val;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference model
  logic [W-1:0] m_t, m_s, m_r;
  logic [W-1:0] m_dmem [D];
  logic [W-1:0] m_rmem [D];
  int           m_dp, m_rp;

  always #(CLK_PER / 2) clk = ~clk;

  dual_stack_cache #(.WORD_W(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst),
    .dpush(dpush), .dpop(dpop), .dwdata(dwdata),
    .rpush(rpush), .rpop(rpop), .rwdata(rwdata),
    .top_t(top_t), .top_s(top_s), .top_r(top_r),
    .dpop_val(dpop_val), .rpop_val(rpop_val)
  );

  function automatic int wrapi(input int v);
    return (v % D + D) % D;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_update(input bit dp, input bit dq, input logic [W-1:0] dw,
                              input bit rp, input bit rq, input logic [W-1:0] rw);
    if (dp && dq) m_t = dw;
    else if (dp) begin
      m_dmem[m_dp] = m_s; m_dp = wrapi(m_dp + 1);
      m_s = m_t; m_t = dw;
    end else if (dq) begin
      m_t = m_s; m_dp = wrapi(m_dp - 1); m_s = m_dmem[m_dp];
    end
    if (rp && rq) m_r = rw;
    else if (rp) begin
      m_rmem[m_rp] = m_r; m_rp = wrapi(m_rp + 1); m_r = rw;
    end else if (rq) begin
      m_rp = wrapi(m_rp - 1); m_r = m_rmem[m_rp];
    end
  endtask

  task automatic step(input bit dp, input bit dq, input logic [W-1:0] dw,
                      input bit rp, input bit rq, input logic [W-1:0] rw,
                      input string tag);
    @(negedge clk);
    dpush = dp; dpop = dq; dwdata = dw;
    rpush = rp; rpop = rq; rwdata = rw;
    #1;
    // R10: removed value visible in the command cycle
    if (dq) check(tag, "dpop_val", dpop_val, m_t);
    if (rq) check(tag, "rpop_val", rpop_val, m_r);
    model_update(dp, dq, dw, rp, rq, rw);
    @(posedge clk);
    #1;
    dpush = 0; dpop = 0; rpush = 0; rpop = 0;
    check(tag, "top_t", top_t, m_t);
    check(tag, "top_s", top_s, m_s);
    check(tag, "top_r", top_r, m_r);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D));
    rst = 1; dpush = 0; dpop = 0; rpush = 0; rpop = 0; dwdata = '0; rwdata = '0;
    m_t = '0; m_s = '0; m_r = '0; m_dp = 0; m_rp = 0;
    for (int k = 0; k < D; k++) begin m_dmem[k] = '0; m_rmem[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1", "top_t after reset", top_t, '0);
    check("R1", "top_s after reset", top_s, '0);
    check("R1", "top_r after reset", top_r, '0);
    rst = 0;

    // R2, R3 directed
    step(1, 0, 18'h00A01, 0, 0, '0, "R2");
    step(1, 0, 18'h00B02, 0, 0, '0, "R2");
    step(1, 0, 18'h00C03, 0, 0, '0, "R2");
    step(0, 1, '0, 0, 0, '0, "R3");
    step(0, 1, '0, 0, 0, '0, "R3");
    // R4, R5 directed
    step(0, 0, '0, 1, 0, 18'h10001, "R4");
    step(0, 0, '0, 1, 0, 18'h10002, "R4");
    step(0, 0, '0, 0, 1, '0, "R5");
    // R9 push and pop together
    step(1, 1, 18'h2ABCD, 1, 1, 18'h31234, "R9");
    // R11 idle
    step(0, 0, 18'h3FFFF, 0, 0, 18'h3FFFF, "R11");
    // R8 both stacks push in the same cycle
    step(1, 0, 18'h05555, 1, 0, 18'h0AAAA, "R8");
    step(0, 1, '0, 1, 0, 18'h01111, "R8");

    // R6 overflow: push 13 onto each stack, then pop 10 newest
    for (int k = 0; k < 13; k++)
      step(1, 0, W'(18'h20000 + k), 1, 0, W'(18'h30000 + k), "R6");
    for (int k = 0; k < 10; k++)
      step(0, 1, '0, 0, 1, '0, "R6");
    // R7 pop beyond the stored entries
    for (int k = 0; k < 6; k++)
      step(0, 1, '0, 0, 1, '0, "R7");

    // Random mixed traffic, R8
    for (int k = 0; k < 4000; k++) begin
      int unsigned sel_d, sel_r;
      sel_d = $urandom % 5;
      sel_r = $urandom % 5;
      step(sel_d inside {1, 2}, sel_d inside {3, 4} || (sel_d == 2 && ($urandom % 4 == 0)),
           W'($urandom),
           sel_r inside {1, 2}, sel_r inside {3, 4} || (sel_r == 2 && ($urandom % 4 == 0)),
           W'($urandom), "R8");
    end

    // R1 reset in mid-run
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check("R1", "top_t mid reset", top_t, '0);
    check("R1", "top_r mid reset", top_r, '0);
    @(negedge clk); rst = 0;

    done = 1;
    summary();
    $finish;
  end
endmodule